// File: doc/BRIEF.md
# SECDED Hamming Codec

This block pairs an encoder and a decoder for a single-error-correcting, double-error-detecting code. The data width can be set from 8 to 64 bits. The encoder takes a data word and appends Hamming check bits. It then adds one overall parity bit. The decoder takes a code word of the same layout. It returns the data with any single-bit error repaired, and raises status flags that say whether an error was seen, repaired, or beyond repair.

The two halves share a clock and an active-high asynchronous clear. Each half has its own enable. A parameter selects whether each half's outputs are registered, which gives one cycle of latency, or driven combinationally. Inside the block, a control module classifies each received word from its syndrome and its overall parity. The control module passes load and correction strobes to the datapaths as a small packed struct.

Top module: `secded_codec`

## Requirements
- R1: The code word is CODE_W = DATA_W + PAR_W + 1 bits wide. Data occupies bits [DATA_W-1:0]. The check bit for Hamming position 2^k sits at bit DATA_W+k. The overall parity bit is the MSB. For DATA_W = 8, data 0xF0 encodes to 0x14F0.
- R2: Data bit i sits at the i-th Hamming position that is not a power of two, counting upward from position 3. Each check bit k gives even parity over every position whose index has bit k set. The overall bit gives even parity over the whole code word.
- R3: PAR_W is the smallest count with 2^PAR_W >= DATA_W + PAR_W + 1. This gives 4 for 8-bit data and 7 for 64-bit data.
- R4: An error-free code word decodes to its data bits unchanged, with all three flags low.
- R5: A code word with exactly one flipped data bit or Hamming check bit decodes to the original data. errAny and errFixed go high and errFatal stays low.
- R6: A code word whose overall parity bit alone is flipped decodes to the original data, with errAny and errFixed high and errFatal low.
- R7: A code word with any two flipped bits raises errAny and errFatal, keeps errFixed low, and returns the received data bits without correction.
- R8: A nonzero syndrome that points past the highest used Hamming position is reported as fatal, even when the overall parity is wrong. The received data bits are returned unchanged.
- R9: With PIPE_OUT = 1, each half's outputs update one clock after an edge at which its enable is high. They hold their value while the enable is low.
- R10: A high aclr forces every registered output to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| aclr | input | 1 | Asynchronous clear, active high |
| encEn | input | 1 | Encoder enable |
| encData | input | DATA_W | Data word to encode |
| encCode | output | CODE_W | Encoded code word |
| decEn | input | 1 | Decoder enable |
| decCode | input | CODE_W | Received code word |
| decData | output | DATA_W | Corrected data |
| errAny | output | 1 | Some error was seen |
| errFixed | output | 1 | The error was corrected |
| errFatal | output | 1 | The error could not be corrected |

## Verification
Some properties are checked by assertions on every cycle:
- every registered code word has even overall parity;
- the low bits of each new code word equal the data that was loaded;
- a received word with even overall parity never comes out marked as corrected;
- a clean word passes through unflagged;
- errFixed and errFatal are never high together;
- outputs hold while the enable is low.

Other behaviour only the bench can show: the exact check-bit values and the repair of each individual bit position. The bench covers both by sweeping all 8-bit data words through every single-bit and every two-bit corruption. It also covers the out-of-range syndrome patterns and the asynchronous clear.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
    logic flipEn;
  } codecStrobe_t;

  typedef enum logic [1:0] {
    CLS_CLEAN   = 2'd0,
    CLS_SINGLE  = 2'd1,
    CLS_OVERALL = 2'd2,
    CLS_FATAL   = 2'd3
  } errClass_e;

  // Smallest check-bit count whose positions can index every code bit.
  function automatic int parityCount(input int dataW);
    int p;
    p = 0;
    for (int q = 1; q <= 8; q++) begin
      if (p == 0 && (1 << q) >= dataW + q + 1) p = q;
    end
    return p;
  endfunction

  // Hamming position of data bit idx: the idx-th non-power-of-two from 3.
  function automatic int dataPos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int pos = 3; pos < 128; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (cnt == idx) res = pos;
        cnt++;
      end
    end
    return res;
  endfunction

  // Data bits covered by check bit k.
  function automatic logic [63:0] coverMask(input int k, input int dataW);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < dataW && ((dataPos(i) >> k) & 1) == 1) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic         encEn,
  input  logic         decEn,
  input  logic         synNonZero,
  input  logic         synInRange,
  input  logic         ovrBad,
  output codecStrobe_t strobe,
  output errClass_e    cls
);

  always_comb begin
    if (!synNonZero) begin
      cls = ovrBad ? CLS_OVERALL : CLS_CLEAN;
    end else if (ovrBad && synInRange) begin
      cls = CLS_SINGLE;
    end else begin
      cls = CLS_FATAL;
    end
  end

  always_comb begin
    strobe.encLoad = encEn;
    strobe.decLoad = decEn;
    strobe.flipEn  = (cls == CLS_SINGLE);
  end

endmodule

// File: rtl/secded_enc_path.sv
module secded_enc_path
  import secded_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAR_W    = 4,
  parameter bit PIPE_OUT = 1'b1,
  localparam int CODE_W  = DATA_W + PAR_W + 1
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);

  logic [PAR_W-1:0]  checkBits;
  logic              overallBit;
  logic [CODE_W-1:0] codeNext;

  for (genvar k = 0; k < PAR_W; k++) begin : g_chk
    localparam logic [63:0] CM = coverMask(k, DATA_W);
    assign checkBits[k] = ^(data & CM[DATA_W-1:0]);
  end

  assign overallBit = (^data) ^ (^checkBits);
  assign codeNext   = {overallBit, checkBits, data};

  if (PIPE_OUT) begin : g_reg
    logic [CODE_W-1:0] codeQ;

    always_ff @(posedge clk or posedge aclr) begin
      if (aclr) codeQ <= '0;
      else if (load) codeQ <= codeNext;
    end

    assign code = codeQ;

    a_r2_overall_even: assert property (@(posedge clk) disable iff (aclr)
      (^code) == 1'b0);

    a_r1_data_low: assert property (@(posedge clk) disable iff (aclr)
      ($past(load) && !$past(aclr)) |-> code[DATA_W-1:0] == $past(data));

    a_r9_enc_hold: assert property (@(posedge clk) disable iff (aclr)
      !load |=> $stable(code));
  end else begin : g_comb
    assign code = codeNext;
  end

endmodule

// File: rtl/secded_dec_path.sv
module secded_dec_path
  import secded_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAR_W    = 4,
  parameter bit PIPE_OUT = 1'b1,
  localparam int CODE_W  = DATA_W + PAR_W + 1
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              load,
  input  logic              flipEn,
  input  errClass_e         cls,
  input  logic [CODE_W-1:0] code,
  output logic              synNonZero,
  output logic              synInRange,
  output logic              ovrBad,
  output logic [DATA_W-1:0] data,
  output logic              flagAny,
  output logic              flagFixed,
  output logic              flagFatal
);

  localparam logic [PAR_W-1:0] MAXPOS = PAR_W'(DATA_W + PAR_W);

  logic [DATA_W-1:0] dataRx;
  logic [PAR_W-1:0]  parRx;
  logic [PAR_W-1:0]  syn;
  logic [DATA_W-1:0] hit;
  logic [DATA_W-1:0] dataFix;
  logic              anyNext, fixedNext, fatalNext;

  assign dataRx = code[DATA_W-1:0];
  assign parRx  = code[DATA_W+PAR_W-1:DATA_W];

  for (genvar k = 0; k < PAR_W; k++) begin : g_syn
    localparam logic [63:0] CM = coverMask(k, DATA_W);
    assign syn[k] = (^(dataRx & CM[DATA_W-1:0])) ^ parRx[k];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    localparam logic [PAR_W-1:0] POSV = PAR_W'(dataPos(i));
    assign hit[i] = (syn == POSV);
  end

  assign synNonZero = |syn;
  assign synInRange = (syn <= MAXPOS);
  assign ovrBad     = ^code;
  assign dataFix    = dataRx ^ (flipEn ? hit : '0);

  assign anyNext   = (cls != CLS_CLEAN);
  assign fixedNext = (cls == CLS_SINGLE) || (cls == CLS_OVERALL);
  assign fatalNext = (cls == CLS_FATAL);

  if (PIPE_OUT) begin : g_reg
    logic [DATA_W-1:0] dataQ;
    logic              anyQ, fixedQ, fatalQ;

    always_ff @(posedge clk or posedge aclr) begin
      if (aclr) begin
        dataQ  <= '0;
        anyQ   <= 1'b0;
        fixedQ <= 1'b0;
        fatalQ <= 1'b0;
      end else if (load) begin
        dataQ  <= dataFix;
        anyQ   <= anyNext;
        fixedQ <= fixedNext;
        fatalQ <= fatalNext;
      end
    end

    assign data      = dataQ;
    assign flagAny   = anyQ;
    assign flagFixed = fixedQ;
    assign flagFatal = fatalQ;

    a_r7_fixed_fatal_excl: assert property (@(posedge clk) disable iff (aclr)
      !(flagFixed && flagFatal));

    a_r7_even_never_fixed: assert property (@(posedge clk) disable iff (aclr)
      $past(load && !ovrBad && !aclr) |-> !flagFixed);

    a_r4_clean_pass: assert property (@(posedge clk) disable iff (aclr)
      $past(load && !synNonZero && !ovrBad && !aclr)
        |-> (data == $past(dataRx)) && !flagAny);

    a_r9_dec_hold: assert property (@(posedge clk) disable iff (aclr)
      !load |=> $stable(data) && $stable(flagAny) && $stable(flagFatal));
  end else begin : g_comb
    assign data      = dataFix;
    assign flagAny   = anyNext;
    assign flagFixed = fixedNext;
    assign flagFatal = fatalNext;
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter bit PIPE_OUT = 1'b1,
  localparam int PAR_W   = parityCount(DATA_W),
  localparam int CODE_W  = DATA_W + PAR_W + 1
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              encEn,
  input  logic [DATA_W-1:0] encData,
  output logic [CODE_W-1:0] encCode,
  input  logic              decEn,
  input  logic [CODE_W-1:0] decCode,
  output logic [DATA_W-1:0] decData,
  output logic              errAny,
  output logic              errFixed,
  output logic              errFatal
);

  codecStrobe_t strobe;
  errClass_e    cls;
  logic         synNonZero, synInRange, ovrBad;

  secded_ctrl u_ctrl (
    .encEn      (encEn),
    .decEn      (decEn),
    .synNonZero (synNonZero),
    .synInRange (synInRange),
    .ovrBad     (ovrBad),
    .strobe     (strobe),
    .cls        (cls)
  );

  secded_enc_path #(
    .DATA_W   (DATA_W),
    .PAR_W    (PAR_W),
    .PIPE_OUT (PIPE_OUT)
  ) u_enc (
    .clk  (clk),
    .aclr (aclr),
    .load (strobe.encLoad),
    .data (encData),
    .code (encCode)
  );

  secded_dec_path #(
    .DATA_W   (DATA_W),
    .PAR_W    (PAR_W),
    .PIPE_OUT (PIPE_OUT)
  ) u_dec (
    .clk        (clk),
    .aclr       (aclr),
    .load       (strobe.decLoad),
    .flipEn     (strobe.flipEn),
    .cls        (cls),
    .code       (decCode),
    .synNonZero (synNonZero),
    .synInRange (synInRange),
    .ovrBad     (ovrBad),
    .data       (decData),
    .flagAny    (errAny),
    .flagFixed  (errFixed),
    .flagFatal  (errFatal)
  );

endmodule

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb;

  localparam int DW = 8;
  localparam int CW = 13;

  logic          clk = 1'b0;
  logic          aclr = 1'b1;
  logic          encEn = 1'b0;
  logic [DW-1:0] encData = '0;
  logic [CW-1:0] encCode;
  logic          decEn = 1'b0;
  logic [CW-1:0] decCode = '0;
  logic [DW-1:0] decData;
  logic          errAny, errFixed, errFatal;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  secded_codec #(.DATA_W(DW), .PIPE_OUT(1'b1)) u_dut (
    .clk(clk), .aclr(aclr), .encEn(encEn), .encData(encData), .encCode(encCode),
    .decEn(decEn), .decCode(decCode), .decData(decData),
    .errAny(errAny), .errFixed(errFixed), .errFatal(errFatal)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference encoder built from R1..R3: 4 check bits for 8 data bits.
  function automatic logic [CW-1:0] refEncode(input logic [DW-1:0] d);
    logic [15:0] h;
    logic [3:0]  p;
    int j;
    h = '0;
    j = 0;
    for (int pos = 1; pos <= 12; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        h[pos] = d[j];
        j++;
      end
    end
    for (int k = 0; k < 4; k++) begin
      p[k] = 1'b0;
      for (int pos = 1; pos <= 12; pos++) if (((pos >> k) & 1) == 1) p[k] ^= h[pos];
    end
    return {(^d) ^ (^p), p, d};
  endfunction

  task automatic encodeOne(input logic [DW-1:0] d);
    @(negedge clk);
    encData = d;
    encEn = 1'b1;
    @(negedge clk);
    encEn = 1'b0;
  endtask

  task automatic decodeOne(input logic [CW-1:0] c);
    @(negedge clk);
    decCode = c;
    decEn = 1'b1;
    @(negedge clk);
    decEn = 1'b0;
  endtask

  initial begin
    logic [CW-1:0] good;
    logic [CW-1:0] bad;
    logic [CW-1:0] held;

    // R10: outputs cleared while aclr is high
    repeat (3) @(negedge clk);
    chk(encCode == '0, "R10 encoder reset", 64'(encCode), 64'h0);
    chk({decData, errAny, errFixed, errFatal} == '0, "R10 decoder reset",
        64'({decData, errAny, errFixed, errFatal}), 64'h0);
    aclr = 1'b0;

    // R1: known vector
    encodeOne(8'hF0);
    chk(encCode == 13'h14F0, "R1 layout of 0xF0", 64'(encCode), 64'h14F0);

    // R9: encoder holds while disabled
    held = encCode;
    @(negedge clk);
    encData = 8'h0F;
    @(negedge clk);
    chk(encCode == held, "R9 encoder hold", 64'(encCode), 64'(held));

    for (int d = 0; d < 256; d++) begin
      good = refEncode(8'(d));
      // R1 R2 R3: every data word encodes to the reference code word
      encodeOne(8'(d));
      chk(encCode == good, "R2 R3 encode", 64'(encCode), 64'(good));

      // R4: clean decode
      decodeOne(good);
      chk({decData, errAny, errFixed, errFatal} == {8'(d), 3'b000}, "R4 clean",
          64'({decData, errAny, errFixed, errFatal}), 64'({8'(d), 3'b000}));

      // R5 (data and check bits) and R6 (overall bit): single flips
      for (int a = 0; a < CW; a++) begin
        decodeOne(good ^ (13'd1 << a));
        chk({decData, errAny, errFixed, errFatal} == {8'(d), 3'b110},
            (a == CW - 1) ? "R6 overall flip" : "R5 single flip",
            64'({decData, errAny, errFixed, errFatal}), 64'({8'(d), 3'b110}));
      end

      // R7: every pair of flips
      for (int a = 0; a < CW; a++) begin
        for (int b = a + 1; b < CW; b++) begin
          bad = good ^ (13'd1 << a) ^ (13'd1 << b);
          decodeOne(bad);
          chk({decData, errAny, errFixed, errFatal} == {bad[DW-1:0], 3'b101}, "R7 double flip",
              64'({decData, errAny, errFixed, errFatal}), 64'({bad[DW-1:0], 3'b101}));
        end
      end
    end

    // R8: syndrome 13 (positions 1,4,8) and 14 (positions 2,4,8), overall parity wrong
    for (int d = 0; d < 256; d += 17) begin
      good = refEncode(8'(d));
      bad = good ^ (13'd1 << 8) ^ (13'd1 << 10) ^ (13'd1 << 11);
      decodeOne(bad);
      chk({decData, errAny, errFixed, errFatal} == {8'(d), 3'b101}, "R8 syndrome 13",
          64'({decData, errAny, errFixed, errFatal}), 64'({8'(d), 3'b101}));
      bad = good ^ (13'd1 << 9) ^ (13'd1 << 10) ^ (13'd1 << 11);
      decodeOne(bad);
      chk({decData, errAny, errFixed, errFatal} == {8'(d), 3'b101}, "R8 syndrome 14",
          64'({decData, errAny, errFixed, errFatal}), 64'({8'(d), 3'b101}));
    end

    // R9: decoder holds while disabled
    decodeOne(refEncode(8'h5A) ^ 13'h1);
    @(negedge clk);
    decCode = refEncode(8'h33) ^ 13'h3;
    @(negedge clk);
    chk({decData, errAny, errFixed, errFatal} == {8'h5A, 3'b110}, "R9 decoder hold",
        64'({decData, errAny, errFixed, errFatal}), 64'({8'h5A, 3'b110}));

    // R10: asynchronous clear mid-cycle
    encodeOne(8'hFF);
    #1 aclr = 1'b1;
    #0.5;
    chk(encCode == '0, "R10 async clear encoder", 64'(encCode), 64'h0);
    chk({decData, errAny, errFixed, errFatal} == '0, "R10 async clear decoder",
        64'({decData, errAny, errFixed, errFatal}), 64'h0);
    @(negedge clk);
    aclr = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule